// File: doc/BRIEF.md
# Hypervisor-Aware Trap Router

This block decides where a trap lands in a core that supports a hypervisor level. When a trap request arrives with its cause and its faulting address, the router weighs the current privilege, the virtualization flag, a force-to-hypervisor flag and four delegation masks. It then picks one of three handlers: machine level, the hypervisor-supervisor level (HS) or the virtual-supervisor level (VS).

In the same step it computes everything the CSR file and the mode logic must record. That covers the next privilege, the next virtualization and force flags, and the new values of the saved status fields for both supervisor and machine. It also yields a one-cycle request to swap the background (guest) register bank, plus the cause and trap value to store. An environment call reaches the router as a single cause and leaves it as the code of the mode it came from.

Delegation takes two steps. The machine masks first decide between machine level and supervisor level. For a supervisor-level trap, a hypervisor mask then decides whether a guest trap stays inside the guest. A configuration input can switch the whole hypervisor part off, which leaves a plain machine/supervisor router.

Top module: `trap_router`

## Requirements
- R1: An exception with cause 8 (environment call) is recorded as 11 from machine privilege (3), 10 from supervisor privilege (1) with virtualization on, 9 from supervisor privilege with virtualization off, and 8 from user privilege (0). The rewritten code is the one used for delegation.
- R2: A trap goes to a supervisor-level target only when the privilege is 1 or 0, the cause is below XLEN, and the cause's bit is set in the machine interrupt mask (for interrupts) or the machine exception mask (for exceptions). Every other trap targets machine level. `rec_target` encodes machine as 2'b11, HS as 2'b01 and VS as 2'b10.
- R3: With the hypervisor enabled, a supervisor-level trap targets VS when three things hold: virtualization is on, the cause's bit is set in the matching hypervisor mask, and the force flag is clear. It then leaves virtualization on, issues no swap and leaves all hypervisor status fields unchanged.
- R4: An HS-targeted trap with the hypervisor enabled moves the old hypervisor previous-virt bit into the second-level previous-virt bit. It moves the old supervisor previous-privilege bit into the second-level previous-privilege bit. It then loads the previous-virt bit with the current virtualization flag.
- R5: An HS-targeted trap taken with virtualization on pulses `swap_bg`, saves the force flag into the hypervisor force-saved bit, and clears both virtualization and the force flag.
- R6: A machine-targeted trap with the hypervisor enabled pulses `swap_bg` only if virtualization was on. It saves virtualization into the machine previous-virt bit and the force flag into the machine force-saved bit, clears virtualization and keeps the force flag.
- R7: A supervisor-level trap copies the supervisor interrupt enable into its previous-enable bit and bit 0 of the old privilege into the supervisor previous-privilege bit, and sets privilege 1. A machine trap copies the machine interrupt enable into its previous-enable bit and the old privilege into the machine previous-privilege field, and sets privilege 3.
- R8: For an exception whose recorded cause is 0, 1, 4, 5, 6, 7, 12, 13 or 15, `rec_tval` takes `trap_addr`. For every other exception it is zero.
- R9: `rec_cause` holds the cause in its low bits and sets its top bit exactly for interrupts. For interrupts `rec_tval` is zero.
- R10: All outputs are registered and load only on a clock edge where `trap_valid` is high. `rec_valid` and `swap_bg` are high for the single cycle after such an edge. Otherwise every other output holds.
- R11: With `hyp_en` low, the hypervisor masks are ignored (no VS target). The hypervisor status fields, machine previous-virt and force-saved bits, virtualization, force flag and swap stay unchanged.
- R12: Synchronous reset sets privilege to 3 and all other outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hyp_en | input | 1 | Hypervisor support enabled |
| trap_valid | input | 1 | Trap request this cycle |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | CAUSE_W | Raw cause code |
| trap_addr | input | XLEN | Faulting address |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| cur_virt | input | 1 | Virtualization flag |
| cur_force_hs | input | 1 | Force-to-HS flag |
| mdeleg_exc | input | XLEN | Machine exception delegation mask |
| mdeleg_irq | input | XLEN | Machine interrupt delegation mask |
| hdeleg_exc | input | XLEN | Hypervisor exception delegation mask |
| hdeleg_irq | input | XLEN | Hypervisor interrupt delegation mask |
| old_s_ie | input | 1 | Supervisor interrupt enable |
| old_m_ie | input | 1 | Machine interrupt enable |
| old_s_prev_ie | input | 1 | Supervisor previous interrupt enable |
| old_s_prev_priv | input | 1 | Supervisor previous privilege |
| old_m_prev_ie | input | 1 | Machine previous interrupt enable |
| old_m_prev_priv | input | 2 | Machine previous privilege |
| old_m_prev_virt | input | 1 | Machine previous virtualization |
| old_m_force_saved | input | 1 | Machine saved force flag |
| old_hs_prev_virt | input | 1 | Hypervisor previous virtualization |
| old_hs_prev2_virt | input | 1 | Hypervisor second-level previous virtualization |
| old_hs_prev2_priv | input | 1 | Hypervisor second-level previous privilege |
| old_hs_force_saved | input | 1 | Hypervisor saved force flag |
| nxt_priv | output | 2 | Next privilege |
| nxt_virt | output | 1 | Next virtualization flag |
| nxt_force_hs | output | 1 | Next force flag |
| nxt_s_prev_ie | output | 1 | New supervisor previous interrupt enable |
| nxt_s_prev_priv | output | 1 | New supervisor previous privilege |
| nxt_m_prev_ie | output | 1 | New machine previous interrupt enable |
| nxt_m_prev_priv | output | 2 | New machine previous privilege |
| nxt_m_prev_virt | output | 1 | New machine previous virtualization |
| nxt_m_force_saved | output | 1 | New machine saved force flag |
| nxt_hs_prev_virt | output | 1 | New hypervisor previous virtualization |
| nxt_hs_prev2_virt | output | 1 | New second-level previous virtualization |
| nxt_hs_prev2_priv | output | 1 | New second-level previous privilege |
| nxt_hs_force_saved | output | 1 | New hypervisor saved force flag |
| swap_bg | output | 1 | One-cycle background register swap request |
| rec_valid | output | 1 | One-cycle marker that the outputs hold a new trap |
| rec_target | output | 2 | Chosen target level |
| rec_cause | output | XLEN | Cause to record |
| rec_tval | output | XLEN | Trap value to record |

## Verification
The environment-call rewrite and the delegation decision act in the same cycle, because the rewritten code, not the raw 8, selects the mask bit. The bench provokes this with calls from supervisor mode with virtualization both on and off. It uses masks that set bit 9 or bit 10 but not both, and masks that set bit 8 alone. A correct router sends only the matching call to the lower level, with the rewritten cause recorded. A second collision, the VS/HS choice together with the swap pulse, is reached by setting the force flag during a delegated guest trap. The result is judged by the target, the cleared flags and the single swap cycle.

// File: rtl/trap_router_pkg.sv
package trap_router_pkg;

  typedef enum logic [1:0] {
    TGT_M  = 2'b11,
    TGT_HS = 2'b01,
    TGT_VS = 2'b10
  } trap_tgt_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  // Raw environment-call code and its rewritten forms
  localparam int unsigned ECALL_RAW  = 8;
  localparam int unsigned ECALL_HS   = 9;
  localparam int unsigned ECALL_VS   = 10;
  localparam int unsigned ECALL_MACH = 11;

  // Exceptions carrying an address: 0,1,4,5,6,7,12,13,15
  localparam logic [15:0] ADDR_INFO_SET = 16'b1011_0000_1111_0011;

  typedef struct packed {
    logic       s_prev_ie;
    logic       s_prev_priv;
    logic       m_prev_ie;
    logic [1:0] m_prev_priv;
    logic       m_prev_virt;
    logic       m_force_saved;
    logic       hs_prev_virt;
    logic       hs_prev2_virt;
    logic       hs_prev2_priv;
    logic       hs_force_saved;
  } trap_stat_t;

endpackage

// File: rtl/trap_cause_fix.sv
module trap_cause_fix
  import trap_router_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned CAUSE_W = 7
) (
  input  logic               is_irq,
  input  logic [CAUSE_W-1:0] cause_in,
  input  logic [1:0]         priv,
  input  logic               virt,
  input  logic [XLEN-1:0]    addr,
  output logic [CAUSE_W-1:0] eff_cause,
  output logic [XLEN-1:0]    rec_cause,
  output logic [XLEN-1:0]    tval
);

  localparam int unsigned PAD_W = XLEN - 1 - CAUSE_W;

  logic addr_info;

  // Environment call: single raw code, rewritten by originating mode
  always_comb begin
    eff_cause = cause_in;
    if (!is_irq && cause_in == CAUSE_W'(ECALL_RAW)) begin
      unique case (priv)
        PRIV_M:  eff_cause = CAUSE_W'(ECALL_MACH);
        PRIV_S:  eff_cause = virt ? CAUSE_W'(ECALL_VS) : CAUSE_W'(ECALL_HS);
        default: eff_cause = cause_in;
      endcase
    end
  end

  always_comb begin
    addr_info = 1'b0;
    if (!is_irq && eff_cause < CAUSE_W'(16))
      addr_info = ADDR_INFO_SET[eff_cause[3:0]];
  end

  assign rec_cause = {is_irq, {PAD_W{1'b0}}, eff_cause};
  assign tval      = addr_info ? addr : '0;

endmodule

// File: rtl/trap_target_sel.sv
module trap_target_sel
  import trap_router_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned CAUSE_W = 7
) (
  input  logic               is_irq,
  input  logic [CAUSE_W-1:0] eff_cause,
  input  logic [1:0]         priv,
  input  logic               virt,
  input  logic               force_hs,
  input  logic               hyp_en,
  input  logic [XLEN-1:0]    mdeleg_exc,
  input  logic [XLEN-1:0]    mdeleg_irq,
  input  logic [XLEN-1:0]    hdeleg_exc,
  input  logic [XLEN-1:0]    hdeleg_irq,
  output trap_tgt_e          tgt
);

  localparam int unsigned IDX_W = $clog2(XLEN);

  logic             in_range;
  logic [IDX_W-1:0] bit_idx;
  logic [XLEN-1:0]  m_mask;
  logic [XLEN-1:0]  h_mask;
  logic             m_hit;
  logic             h_hit;
  logic             to_super;

  // Range check only exists when the cause field can exceed XLEN-1
  generate
    if (CAUSE_W > IDX_W) begin : g_range_chk
      assign in_range = (eff_cause < CAUSE_W'(XLEN));
    end else begin : g_range_free
      assign in_range = 1'b1;
    end
  endgenerate

  assign bit_idx  = eff_cause[IDX_W-1:0];
  assign m_mask   = is_irq ? mdeleg_irq : mdeleg_exc;
  assign h_mask   = is_irq ? hdeleg_irq : hdeleg_exc;
  assign m_hit    = m_mask[bit_idx];
  assign h_hit    = h_mask[bit_idx];
  assign to_super = (priv == PRIV_U || priv == PRIV_S) && in_range && m_hit;

  always_comb begin
    if (!to_super)
      tgt = TGT_M;
    else if (hyp_en && virt && h_hit && !force_hs)
      tgt = TGT_VS;
    else
      tgt = TGT_HS;
  end

endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd
  import trap_router_pkg::*;
(
  input  trap_tgt_e  tgt,
  input  logic       hyp_en,
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       force_hs,
  input  logic       s_ie,
  input  logic       m_ie,
  input  trap_stat_t old_st,
  output trap_stat_t new_st,
  output logic [1:0] new_priv,
  output logic       new_virt,
  output logic       new_force,
  output logic       swap
);

  always_comb begin
    new_st    = old_st;
    new_priv  = priv;
    new_virt  = virt;
    new_force = force_hs;
    swap      = 1'b0;
    if (tgt == TGT_M) begin
      new_st.m_prev_ie   = m_ie;
      new_st.m_prev_priv = priv;
      new_priv           = PRIV_M;
      if (hyp_en) begin
        swap                 = virt;
        new_st.m_prev_virt   = virt;
        new_st.m_force_saved = force_hs;
        new_virt             = 1'b0;
      end
    end else begin
      new_st.s_prev_ie   = s_ie;
      new_st.s_prev_priv = priv[0];
      new_priv           = PRIV_S;
      if (tgt == TGT_HS && hyp_en) begin
        // ordered chain: second level takes the old first level
        new_st.hs_prev2_virt = old_st.hs_prev_virt;
        new_st.hs_prev2_priv = old_st.s_prev_priv;
        new_st.hs_prev_virt  = virt;
        if (virt) begin
          swap                  = 1'b1;
          new_st.hs_force_saved = force_hs;
          new_virt              = 1'b0;
          new_force             = 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/trap_router.sv
module trap_router
  import trap_router_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned CAUSE_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hyp_en,
  input  logic               trap_valid,
  input  logic               trap_is_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    trap_addr,
  input  logic [1:0]         cur_priv,
  input  logic               cur_virt,
  input  logic               cur_force_hs,
  input  logic [XLEN-1:0]    mdeleg_exc,
  input  logic [XLEN-1:0]    mdeleg_irq,
  input  logic [XLEN-1:0]    hdeleg_exc,
  input  logic [XLEN-1:0]    hdeleg_irq,
  input  logic               old_s_ie,
  input  logic               old_m_ie,
  input  logic               old_s_prev_ie,
  input  logic               old_s_prev_priv,
  input  logic               old_m_prev_ie,
  input  logic [1:0]         old_m_prev_priv,
  input  logic               old_m_prev_virt,
  input  logic               old_m_force_saved,
  input  logic               old_hs_prev_virt,
  input  logic               old_hs_prev2_virt,
  input  logic               old_hs_prev2_priv,
  input  logic               old_hs_force_saved,
  output logic [1:0]         nxt_priv,
  output logic               nxt_virt,
  output logic               nxt_force_hs,
  output logic               nxt_s_prev_ie,
  output logic               nxt_s_prev_priv,
  output logic               nxt_m_prev_ie,
  output logic [1:0]         nxt_m_prev_priv,
  output logic               nxt_m_prev_virt,
  output logic               nxt_m_force_saved,
  output logic               nxt_hs_prev_virt,
  output logic               nxt_hs_prev2_virt,
  output logic               nxt_hs_prev2_priv,
  output logic               nxt_hs_force_saved,
  output logic               swap_bg,
  output logic               rec_valid,
  output logic [1:0]         rec_target,
  output logic [XLEN-1:0]    rec_cause,
  output logic [XLEN-1:0]    rec_tval
);

  logic [CAUSE_W-1:0] eff_cause;
  logic [XLEN-1:0]    cause_c;
  logic [XLEN-1:0]    tval_c;
  trap_tgt_e          tgt_c;
  trap_stat_t         old_st;
  trap_stat_t         new_st;
  trap_stat_t         st_q;
  logic [1:0]         priv_c;
  logic               virt_c;
  logic               force_c;
  logic               swap_c;

  assign old_st = '{
    s_prev_ie:      old_s_prev_ie,
    s_prev_priv:    old_s_prev_priv,
    m_prev_ie:      old_m_prev_ie,
    m_prev_priv:    old_m_prev_priv,
    m_prev_virt:    old_m_prev_virt,
    m_force_saved:  old_m_force_saved,
    hs_prev_virt:   old_hs_prev_virt,
    hs_prev2_virt:  old_hs_prev2_virt,
    hs_prev2_priv:  old_hs_prev2_priv,
    hs_force_saved: old_hs_force_saved
  };

  trap_cause_fix #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) cause_i (
    .is_irq    (trap_is_irq),
    .cause_in  (trap_cause),
    .priv      (cur_priv),
    .virt      (cur_virt),
    .addr      (trap_addr),
    .eff_cause (eff_cause),
    .rec_cause (cause_c),
    .tval      (tval_c)
  );

  trap_target_sel #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) sel_i (
    .is_irq     (trap_is_irq),
    .eff_cause  (eff_cause),
    .priv       (cur_priv),
    .virt       (cur_virt),
    .force_hs   (cur_force_hs),
    .hyp_en     (hyp_en),
    .mdeleg_exc (mdeleg_exc),
    .mdeleg_irq (mdeleg_irq),
    .hdeleg_exc (hdeleg_exc),
    .hdeleg_irq (hdeleg_irq),
    .tgt        (tgt_c)
  );

  trap_status_upd upd_i (
    .tgt       (tgt_c),
    .hyp_en    (hyp_en),
    .priv      (cur_priv),
    .virt      (cur_virt),
    .force_hs  (cur_force_hs),
    .s_ie      (old_s_ie),
    .m_ie      (old_m_ie),
    .old_st    (old_st),
    .new_st    (new_st),
    .new_priv  (priv_c),
    .new_virt  (virt_c),
    .new_force (force_c),
    .swap      (swap_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_priv     <= PRIV_M;
      nxt_virt     <= 1'b0;
      nxt_force_hs <= 1'b0;
      st_q         <= '0;
      swap_bg      <= 1'b0;
      rec_valid    <= 1'b0;
      rec_target   <= 2'b00;
      rec_cause    <= '0;
      rec_tval     <= '0;
    end else begin
      swap_bg   <= trap_valid & swap_c;
      rec_valid <= trap_valid;
      if (trap_valid) begin
        nxt_priv     <= priv_c;
        nxt_virt     <= virt_c;
        nxt_force_hs <= force_c;
        st_q         <= new_st;
        rec_target   <= tgt_c;
        rec_cause    <= cause_c;
        rec_tval     <= tval_c;
      end
    end
  end

  assign nxt_s_prev_ie      = st_q.s_prev_ie;
  assign nxt_s_prev_priv    = st_q.s_prev_priv;
  assign nxt_m_prev_ie      = st_q.m_prev_ie;
  assign nxt_m_prev_priv    = st_q.m_prev_priv;
  assign nxt_m_prev_virt    = st_q.m_prev_virt;
  assign nxt_m_force_saved  = st_q.m_force_saved;
  assign nxt_hs_prev_virt   = st_q.hs_prev_virt;
  assign nxt_hs_prev2_virt  = st_q.hs_prev2_virt;
  assign nxt_hs_prev2_priv  = st_q.hs_prev2_priv;
  assign nxt_hs_force_saved = st_q.hs_force_saved;

endmodule

// File: rtl/trap_router_chk.sv
module trap_router_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            trap_valid,
  input logic            hyp_en,
  input logic [1:0]      cur_priv,
  input logic [1:0]      o_priv,
  input logic            o_virt,
  input logic [1:0]      o_target,
  input logic            o_swap,
  input logic            o_rec_valid,
  input logic            o_irq_bit,
  input logic [XLEN-1:0] o_tval
);

  assert_hold_priv_R10: assert property (@(posedge clk) disable iff (rst)
    !trap_valid |=> $stable(o_priv) && !o_swap && !o_rec_valid);

  assert_machine_stays_R2: assert property (@(posedge clk) disable iff (rst)
    trap_valid && cur_priv == 2'd3 |=> o_target == 2'b11);

  assert_guest_keeps_virt_R3: assert property (@(posedge clk) disable iff (rst)
    trap_valid && hyp_en |=> ((o_target == 2'b10) == o_virt));

  assert_swap_leaves_guest_R5: assert property (@(posedge clk) disable iff (rst)
    o_swap |-> o_rec_valid && o_target != 2'b10 && !o_virt);

  assert_priv_matches_target_R7: assert property (@(posedge clk) disable iff (rst)
    o_rec_valid |-> o_priv == ((o_target == 2'b11) ? 2'd3 : 2'd1));

  assert_irq_no_tval_R9: assert property (@(posedge clk) disable iff (rst)
    o_rec_valid && o_irq_bit |-> o_tval == '0);

endmodule

bind trap_router trap_router_chk #(.XLEN(XLEN)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .trap_valid  (trap_valid),
  .hyp_en      (hyp_en),
  .cur_priv    (cur_priv),
  .o_priv      (nxt_priv),
  .o_virt      (nxt_virt),
  .o_target    (rec_target),
  .o_swap      (swap_bg),
  .o_rec_valid (rec_valid),
  .o_irq_bit   (rec_cause[XLEN-1]),
  .o_tval      (rec_tval)
);

// File: tb/trap_router_tb_top.sv
module trap_router_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic hyp_en = 0, trap_valid = 0, is_irq = 0;
  logic [6:0] cause = 0;
  logic [63:0] addr = 0, dme = 0, dmi = 0, dhe = 0, dhi = 0;
  logic [1:0] priv = 0;
  logic virt = 0, frc = 0, s_ie = 0, m_ie = 0;
  logic o_spie = 0, o_spp = 0, o_mpie = 0, o_mpv = 0, o_mtl = 0;
  logic o_hpv = 0, o_hp2v = 0, o_hp2p = 0, o_hfs = 0;
  logic [1:0] o_mpp = 0;

  logic [1:0] q_priv, q_mpp, q_tgt;
  logic q_virt, q_frc, q_spie, q_spp, q_mpie, q_mpv, q_mtl;
  logic q_hpv, q_hp2v, q_hp2p, q_hfs, q_swap, q_rv;
  logic [63:0] q_cause, q_tval;

  trap_router dut_i (
    .clk(clk), .rst(rst), .hyp_en(hyp_en), .trap_valid(trap_valid),
    .trap_is_irq(is_irq), .trap_cause(cause), .trap_addr(addr),
    .cur_priv(priv), .cur_virt(virt), .cur_force_hs(frc),
    .mdeleg_exc(dme), .mdeleg_irq(dmi), .hdeleg_exc(dhe), .hdeleg_irq(dhi),
    .old_s_ie(s_ie), .old_m_ie(m_ie), .old_s_prev_ie(o_spie),
    .old_s_prev_priv(o_spp), .old_m_prev_ie(o_mpie), .old_m_prev_priv(o_mpp),
    .old_m_prev_virt(o_mpv), .old_m_force_saved(o_mtl),
    .old_hs_prev_virt(o_hpv), .old_hs_prev2_virt(o_hp2v),
    .old_hs_prev2_priv(o_hp2p), .old_hs_force_saved(o_hfs),
    .nxt_priv(q_priv), .nxt_virt(q_virt), .nxt_force_hs(q_frc),
    .nxt_s_prev_ie(q_spie), .nxt_s_prev_priv(q_spp), .nxt_m_prev_ie(q_mpie),
    .nxt_m_prev_priv(q_mpp), .nxt_m_prev_virt(q_mpv),
    .nxt_m_force_saved(q_mtl), .nxt_hs_prev_virt(q_hpv),
    .nxt_hs_prev2_virt(q_hp2v), .nxt_hs_prev2_priv(q_hp2p),
    .nxt_hs_force_saved(q_hfs), .swap_bg(q_swap), .rec_valid(q_rv),
    .rec_target(q_tgt), .rec_cause(q_cause), .rec_tval(q_tval)
  );

  int total = 0;
  int bad = 0;

  // expected values
  logic [1:0] e_priv, e_mpp, e_tgt;
  logic e_virt, e_frc, e_spie, e_spp, e_mpie, e_mpv, e_mtl;
  logic e_hpv, e_hp2v, e_hp2p, e_hfs, e_swap;
  logic [63:0] e_cause, e_tval;
  logic [6:0] ec;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic addr_kind(input logic [6:0] c);
    return c inside {7'd0, 7'd1, 7'd4, 7'd5, 7'd6, 7'd7, 7'd12, 7'd13, 7'd15};
  endfunction

  task automatic model();
    logic [63:0] md, hd;
    logic sdel;
    ec = cause;
    if (!is_irq && cause == 7'd8) begin
      if (priv == 2'd3) ec = 7'd11;
      else if (priv == 2'd1) ec = virt ? 7'd10 : 7'd9;
    end
    md = is_irq ? dmi : dme;
    hd = is_irq ? dhi : dhe;
    sdel = (priv <= 2'd1) && (ec < 7'd64) && md[ec[5:0]];
    e_priv = priv; e_virt = virt; e_frc = frc; e_swap = 0;
    e_spie = o_spie; e_spp = o_spp; e_mpie = o_mpie; e_mpp = o_mpp;
    e_mpv = o_mpv; e_mtl = o_mtl; e_hpv = o_hpv; e_hp2v = o_hp2v;
    e_hp2p = o_hp2p; e_hfs = o_hfs;
    if (sdel) begin
      e_spie = s_ie; e_spp = priv[0]; e_priv = 2'd1;
      if (hyp_en && virt && hd[ec[5:0]] && !frc) e_tgt = 2'b10;
      else begin
        e_tgt = 2'b01;
        if (hyp_en) begin
          e_hp2v = o_hpv; e_hp2p = o_spp; e_hpv = virt;
          if (virt) begin e_swap = 1; e_hfs = frc; e_virt = 0; e_frc = 0; end
        end
      end
    end else begin
      e_tgt = 2'b11; e_mpie = m_ie; e_mpp = priv; e_priv = 2'd3;
      if (hyp_en) begin e_swap = virt; e_mpv = virt; e_mtl = frc; e_virt = 0; end
    end
    e_cause = {is_irq, 56'd0, ec};
    e_tval = (!is_irq && addr_kind(ec)) ? addr : 64'd0;
  endtask

  task automatic rnd_status();
    {s_ie, m_ie, o_spie, o_spp, o_mpie, o_mpv, o_mtl} = 7'($urandom);
    {o_hpv, o_hp2v, o_hp2p, o_hfs} = 4'($urandom);
    o_mpp = 2'($urandom);
  endtask

  task automatic rnd_all();
    int k;
    hyp_en = ($urandom % 5) != 0;
    is_irq = $urandom % 2;
    k = $urandom % 8;
    cause = (k == 0) ? 7'($urandom) : ((k == 1) ? 7'd8 : 7'($urandom % 16));
    addr = {$urandom, $urandom};
    k = $urandom % 8;
    priv = (k == 0) ? 2'd2 : ((k < 3) ? 2'd3 : ((k < 5) ? 2'd1 : 2'd0));
    virt = $urandom % 2;
    frc = ($urandom % 4) == 0;
    dme = {$urandom, $urandom}; dmi = {$urandom, $urandom};
    dhe = {$urandom, $urandom}; dhi = {$urandom, $urandom};
    if (($urandom % 4) == 0) begin dme = '1; dmi = '1; end
    rnd_status();
  endtask

  task automatic check_all(input string tag);
    string rt, rc, rv, rs;
    rt = (e_tgt == 2'b10) ? "R3 target" : "R2 target";
    rc = (!is_irq && cause == 7'd8) ? "R1 cause" : "R9 cause";
    rv = is_irq ? "R9 tval" : "R8 tval";
    rs = (e_tgt == 2'b11) ? "R6 swap" : "R5 swap";
    chk({tag, " ", rt}, 64'(q_tgt), 64'(e_tgt));
    chk({tag, " ", rc}, q_cause, e_cause);
    chk({tag, " ", rv}, q_tval, e_tval);
    chk({tag, " R7 priv/prev fields"}, 64'({q_priv, q_spie, q_spp, q_mpie, q_mpp}),
        64'({e_priv, e_spie, e_spp, e_mpie, e_mpp}));
    chk({tag, hyp_en ? " R4 hs fields" : " R11 hs fields"},
        64'({q_hp2v, q_hp2p, q_hpv, q_hfs}), 64'({e_hp2v, e_hp2p, e_hpv, e_hfs}));
    chk({tag, hyp_en ? " R6 m virt/force" : " R11 m virt/force"},
        64'({q_mpv, q_mtl}), 64'({e_mpv, e_mtl}));
    chk({tag, hyp_en ? " R5 virt/force" : " R11 virt/force"},
        64'({q_virt, q_frc}), 64'({e_virt, e_frc}));
    chk({tag, " ", rs}, 64'(q_swap), 64'(e_swap));
  endtask

  // inputs stable at call, drives trap, checks, then one idle hold cycle
  task automatic do_trap(input string tag);
    model();
    trap_valid = 1;
    @(negedge clk);
    trap_valid = 0;
    chk({tag, " R10 rec_valid pulse"}, 64'(q_rv), 64'd1);
    check_all(tag);
    rnd_all();
    @(negedge clk);
    chk({tag, " R10 hold"}, {q_priv, q_virt, q_frc, q_tgt, q_swap, q_rv, q_tval[56:0]},
        {e_priv, e_virt, e_frc, e_tgt, 1'b0, 1'b0, e_tval[56:0]});
    chk({tag, " R10 hold cause"}, q_cause, e_cause);
  endtask

  task automatic base(input logic h, input logic [1:0] p, input logic v, input logic f);
    rnd_status();
    hyp_en = h; priv = p; virt = v; frc = f; is_irq = 0;
    addr = 64'hDEAD_BEEF_0123_4567;
    dme = '0; dmi = '0; dhe = '0; dhi = '0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R12 reset priv", 64'(q_priv), 64'd3);
    chk("R12 reset others", {q_cause[31:0], q_tval[31:0]}, 64'd0);
    chk("R12 reset flags", 64'({q_virt, q_frc, q_swap, q_rv, q_tgt, q_spie, q_spp, q_mpie,
        q_mpp, q_mpv, q_mtl, q_hpv, q_hp2v, q_hp2p, q_hfs}), 64'd0);

    // R1 ecall from each mode, full machine delegation
    base(1, 2'd3, 0, 0); cause = 8; dme = '1; do_trap("ecall M");
    base(1, 2'd1, 1, 0); cause = 8; dme = '1; do_trap("ecall VS");
    base(1, 2'd1, 0, 0); cause = 8; dme = '1; do_trap("ecall HS");
    base(1, 2'd0, 0, 0); cause = 8; dme = '1; do_trap("ecall U");
    // R1 + R2: rewritten code picks the mask bit
    base(1, 2'd1, 1, 0); cause = 8; dme = 64'h200; do_trap("ecall mask9 virt");
    base(1, 2'd1, 0, 0); cause = 8; dme = 64'h200; do_trap("ecall mask9 novirt");
    base(1, 2'd1, 1, 0); cause = 8; dme = 64'h100; do_trap("ecall mask8 virt");
    // R2 cause beyond XLEN
    base(1, 2'd0, 0, 0); cause = 7'd100; dme = '1; dmi = '1; do_trap("cause range");
    // R3 guest keeps trap
    base(1, 2'd0, 1, 0); cause = 13; dme = '1; dhe = '1; do_trap("stay VS");
    // R5 force flag sends to HS with swap
    base(1, 2'd0, 1, 1); cause = 13; dme = '1; dhe = '1; do_trap("force HS");
    // R6 machine trap from guest
    base(1, 2'd1, 1, 1); cause = 2; do_trap("M from guest");
    // R11 hypervisor off
    base(0, 2'd0, 1, 1); cause = 5; dme = '1; dhe = '1; do_trap("hyp off S");
    base(0, 2'd1, 1, 0); cause = 5; do_trap("hyp off M");
    // R9 interrupt
    base(1, 2'd0, 0, 0); is_irq = 1; cause = 5; dmi = '1; do_trap("irq");

    for (int i = 0; i < 600; i++) begin
      rnd_all();
      do_trap("random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule